// File: doc/BRIEF.md
# I2C Pointer-Register Slave

This block is an I2C target. It watches serial clock and data lines that have already been synchronised to the system clock. When it takes the data line low, it does so through an open-drain enable. The seven-bit bus address has two parts. The upper bits are a fixed prefix, `1001` by default. The low three bits come from strap pins, so up to eight copies can share one bus.

Register access goes through an internal pointer. In a write transfer, the first byte after the address loads the pointer. Every later byte of the same transfer writes the selected register through a small register-file port (address, write data, one-cycle write strobe). The port always presents the pointer as the address.

In a read transfer, the block returns the register the pointer selects. It reads that register again before each byte. The pointer does not advance, and it keeps its value between transfers. A pointer-only write followed by a repeated start in read direction therefore reads the selected register. The block also raises a busy flag from an address match until the next stop condition.

Top module: `i2c_ptr_slave`

## Requirements
- R1: After a start condition (data falling while the clock is high), the block shifts in seven address bits, most significant first, then the direction bit. If the address equals `{PREFIX, strap_i}`, `sda_oe` rises one cycle after the eighth clock's falling edge and falls one cycle after the ninth clock's falling edge.
- R2: If the address does not match, `sda_oe`, `reg_we` and `bus_busy` stay low for the rest of the transfer, whatever bytes follow. The block responds again only after a new start.
- R3: In a write transfer (direction bit 0), the first byte sets the pointer to its low `PTR_W` bits and is acknowledged. It causes no register write. `reg_addr` shows the pointer from one cycle after that byte's eighth falling clock edge.
- R4: Each later byte of a write transfer produces exactly one cycle of `reg_we`, with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer, and is acknowledged.
- R5: In a read transfer (direction bit 1), one cycle after the acknowledge clock's falling edge the block captures `reg_rdata` and drives its bit 7. Each later bit is driven one cycle after the next falling clock edge. A 0 bit means `sda_oe`=1. The drive changes only while the clock is low.
- R6: When the controller acknowledges a read byte (data low on the ninth clock), the next byte is recaptured from `reg_rdata`. After a no-acknowledge, the block releases the line and drives nothing until the next start.
- R7: `bus_busy` rises together with the address acknowledge, stays high through repeated starts, and falls on a stop or on a non-matching address.
- R8: A stop condition (data rising while the clock is high) clears `sda_oe` and `bus_busy` on the next cycle.
- R9: The direction is fixed by the bit after each start. The pointer is kept across transfers, so a repeated start in read direction returns the register chosen by the preceding write.
- R10: After reset, `sda_oe`, `reg_we` and `bus_busy` are 0, and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (resolved bus value) |
| strap_i | input | 3 | Pin-strapped low address bits |
| sda_oe | output | 1 | Pull the data line low when 1 |
| reg_addr | output | PTR_W | Register index (the pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Data of the register at `reg_addr` |
| bus_busy | output | 1 | High from an address match until the next stop |

## Verification
The bench goes after the cases listed below.

- **Pointer-only write.** A design that wrote the pointer byte into a register would show an extra write strobe.
- **Pointer byte with high bits set.** A design that failed to mask those bits would point at the wrong register.
- **Non-matching address followed by data bytes.** A design that kept decoding would acknowledge those bytes or write them.
- **Read ended by a no-acknowledge, then one more byte clocked.** A design that kept driving would return anything other than all ones.
- **Repeated start that turns a write into a read.** The read must return the pointed register, and the busy flag must stay high.
- **Strap change.** The old address must then be refused.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    localparam int BYTE_W     = 8;
    localparam int DEV_ADDR_W = 7;
    localparam int CNT_W      = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } slv_state_e;

endpackage

// File: rtl/i2c_line_mon.sv
// Edge and bus-condition detector for already synchronised SCL/SDA.
module i2c_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d     = line_q;
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            line_q <= line_d;
        end
    end

    // Conditions on SDA count only while SCL is high in both samples.
    assign scl_rise  =  scl_i & ~line_q.scl;
    assign scl_fall  = ~scl_i &  line_q.scl;
    assign bus_start =  scl_i &  line_q.scl &  line_q.sda & ~sda_i;
    assign bus_stop  =  scl_i &  line_q.scl & ~line_q.sda &  sda_i;

endmodule

// File: rtl/i2c_addr_match.sv
// Compares a received 7-bit address with {fixed prefix, strap pins}.
module i2c_addr_match #(
    parameter int          PREFIX_W = 4,
    parameter logic [PREFIX_W-1:0] PREFIX = 4'b1001,
    localparam int         STRAP_W  = i2c_ptr_pkg::DEV_ADDR_W - PREFIX_W
) (
    input  logic [i2c_ptr_pkg::DEV_ADDR_W-1:0] addr_rx,
    input  logic [STRAP_W-1:0]                 strap_i,
    output logic                               hit
);

    localparam int AW = i2c_ptr_pkg::DEV_ADDR_W;

    logic [AW-1:0] own_addr;
    logic [AW-1:0] bit_eq;

    assign own_addr = {PREFIX, strap_i};

    for (genvar gi = 0; gi < AW; gi++) begin : g_bit
        assign bit_eq[gi] = ~(addr_rx[gi] ^ own_addr[gi]);
    end

    assign hit = &bit_eq;

endmodule

// File: rtl/i2c_ptr_engine.sv
// Transfer sequencer: address phase, pointer/data writes, register reads.
module i2c_ptr_engine #(
    parameter int PTR_W = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               scl_rise,
    input  logic                               scl_fall,
    input  logic                               bus_start,
    input  logic                               bus_stop,
    input  logic                               sda_i,
    input  logic                               addr_hit,
    input  logic [i2c_ptr_pkg::BYTE_W-1:0]     reg_rdata,
    output logic [i2c_ptr_pkg::DEV_ADDR_W-1:0] rx_addr,
    output logic                               sda_oe,
    output logic [PTR_W-1:0]                   reg_addr,
    output logic [i2c_ptr_pkg::BYTE_W-1:0]     reg_wdata,
    output logic                               reg_we,
    output logic                               bus_busy
);
    import i2c_ptr_pkg::*;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        slv_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              first;
        logic              mack;
        logic              oe;
        logic              busy;
        logic              we;
        logic [BYTE_W-1:0] wdata;
        logic [PTR_W-1:0]  ptr;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d    = eng_q;
        eng_d.we = 1'b0;
        if (bus_stop) begin
            eng_d.st   = ST_IDLE;
            eng_d.oe   = 1'b0;
            eng_d.busy = 1'b0;
        end else if (bus_start) begin
            eng_d.st  = ST_ADDR;
            eng_d.cnt = '0;
            eng_d.oe  = 1'b0;
        end else begin
            case (eng_q.st)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        eng_d.sh  = {eng_q.sh[BYTE_W-2:0], sda_i};
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end else if (scl_fall && eng_q.cnt == LAST_BIT) begin
                        if (eng_q.st == ST_ADDR) begin
                            if (addr_hit) begin
                                eng_d.st    = ST_ADDR_ACK;
                                eng_d.oe    = 1'b1;
                                eng_d.busy  = 1'b1;
                                eng_d.rw    = eng_q.sh[0];
                                eng_d.first = 1'b1;
                            end else begin
                                eng_d.st   = ST_IDLE;
                                eng_d.busy = 1'b0;
                            end
                        end else begin
                            eng_d.st = ST_WR_ACK;
                            eng_d.oe = 1'b1;
                            if (eng_q.first) begin
                                eng_d.ptr   = eng_q.sh[PTR_W-1:0];
                                eng_d.first = 1'b0;
                            end else begin
                                eng_d.we    = 1'b1;
                                eng_d.wdata = eng_q.sh;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        eng_d.cnt = '0;
                        if (eng_q.st == ST_ADDR_ACK && eng_q.rw) begin
                            eng_d.st = ST_RD_BYTE;
                            eng_d.sh = reg_rdata;
                            eng_d.oe = ~reg_rdata[BYTE_W-1];
                        end else begin
                            eng_d.st = ST_WR_BYTE;
                            eng_d.oe = 1'b0;
                        end
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (eng_q.cnt == LAST_BIT) begin
                            eng_d.st = ST_RD_ACK;
                            eng_d.oe = 1'b0;
                        end else begin
                            eng_d.sh = {eng_q.sh[BYTE_W-2:0], 1'b0};
                            eng_d.oe = ~eng_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        eng_d.mack = ~sda_i;
                    end else if (scl_fall) begin
                        if (eng_q.mack) begin
                            eng_d.st  = ST_RD_BYTE;
                            eng_d.cnt = '0;
                            eng_d.sh  = reg_rdata;
                            eng_d.oe  = ~reg_rdata[BYTE_W-1];
                        end else begin
                            eng_d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, cnt: '0, sh: '0, rw: 1'b0, first: 1'b0,
                       mack: 1'b0, oe: 1'b0, busy: 1'b0, we: 1'b0,
                       wdata: '0, ptr: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign rx_addr   = eng_q.sh[BYTE_W-1:1];
    assign sda_oe    = eng_q.oe;
    assign reg_addr  = eng_q.ptr;
    assign reg_wdata = eng_q.wdata;
    assign reg_we    = eng_q.we;
    assign bus_busy  = eng_q.busy;

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
    parameter int PTR_W    = 3,
    parameter int PREFIX_W = 4,
    parameter logic [PREFIX_W-1:0] PREFIX = 4'b1001,
    localparam int STRAP_W = i2c_ptr_pkg::DEV_ADDR_W - PREFIX_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           scl_i,
    input  logic                           sda_i,
    input  logic [STRAP_W-1:0]             strap_i,
    output logic                           sda_oe,
    output logic [PTR_W-1:0]               reg_addr,
    output logic [i2c_ptr_pkg::BYTE_W-1:0] reg_wdata,
    output logic                           reg_we,
    input  logic [i2c_ptr_pkg::BYTE_W-1:0] reg_rdata,
    output logic                           bus_busy
);

    logic scl_rise, scl_fall, bus_start, bus_stop, addr_hit;
    logic [i2c_ptr_pkg::DEV_ADDR_W-1:0] rx_addr;

    i2c_line_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_addr_match #(
        .PREFIX_W (PREFIX_W),
        .PREFIX   (PREFIX)
    ) u_match (
        .addr_rx (rx_addr),
        .strap_i (strap_i),
        .hit     (addr_hit)
    );

    i2c_ptr_engine #(
        .PTR_W (PTR_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_i     (sda_i),
        .addr_hit  (addr_hit),
        .reg_rdata (reg_rdata),
        .rx_addr   (rx_addr),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .bus_busy  (bus_busy)
    );

endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sda_oe,
    input logic reg_we,
    input logic bus_busy
);

    // R5: the line drive moves only while the clock is low
    assert_drive_on_low_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R4: a register write strobe lasts a single cycle
    assert_we_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R2: no drive on the line unless addressed
    assert_no_drive_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> !sda_oe);

    // R3: register writes happen only inside a selected transfer
    assert_write_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> bus_busy);

    // R8: a stop on the bus releases the line and clears busy
    assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> (!bus_busy && !sda_oe));

endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .bus_busy (bus_busy)
);

// File: tb/sim_i2c_ptr_slave.sv
`timescale 1ns/1ps
module sim_i2c_ptr_slave;

    localparam int PTR_W = 3;
    localparam int QTR   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_oe, reg_we, bus_busy;
    logic [PTR_W-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic sda_line;
    logic [7:0] mem [0:7];

    int checks = 0;
    int fails = 0;
    int we_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_ptr_slave #(.PTR_W(PTR_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .strap_i   (strap),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .bus_busy  (bus_busy)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(8'h3B + i * 8'h29);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
    endtask

    // ---------------- behavioural reference, evaluated every clock -------------
    int ph = 0;            // 0 idle, 1 address, 2 write, 3 read
    int k = 0;             // bit slot within the current 9-clock frame
    int x_ptr = 0;
    logic [7:0] sbits = '0, dbyte = '0, x_wdata = '0;
    bit m_rw, m_first, m_ok, x_oe, x_busy, x_we;
    bit p_scl = 1'b1, p_sda = 1'b1;
    bit ev_st, ev_sp, ev_rs, ev_fl;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; k = 0; x_ptr = 0; sbits = '0; dbyte = '0; x_wdata = '0;
            m_rw = 0; m_first = 0; m_ok = 0; x_oe = 0; x_busy = 0; x_we = 0;
            p_scl = 1; p_sda = 1;
            for (int i = 0; i < 8; i++) mem[i] <= init_val(i);
        end else begin
            if (reg_we) begin
                mem[reg_addr] <= reg_wdata;
                we_cnt++;
            end
            ev_st = m_scl && p_scl && p_sda && !sda_line;
            ev_sp = m_scl && p_scl && !p_sda && sda_line;
            ev_rs = m_scl && !p_scl;
            ev_fl = !m_scl && p_scl;
            x_we = 0;
            if (ev_sp) begin
                ph = 0; x_oe = 0; x_busy = 0;
            end else if (ev_st) begin
                ph = 1; k = 0; x_oe = 0;
            end else if (ph != 0) begin
                if (ev_rs) begin
                    k++;
                    if (k <= 8 && ph != 3) sbits = {sbits[6:0], sda_line};
                    if (k == 9 && ph == 3) m_ok = !sda_line;
                end else if (ev_fl) begin
                    if (k == 8) begin
                        if (ph == 1) begin
                            if (sbits[7:1] == {4'b1001, strap}) begin
                                x_oe = 1; x_busy = 1; m_rw = sbits[0]; m_first = 1;
                            end else begin
                                ph = 0; x_busy = 0;
                            end
                        end else if (ph == 2) begin
                            x_oe = 1;
                            if (m_first) begin
                                x_ptr = int'(sbits) % (1 << PTR_W);
                                m_first = 0;
                            end else begin
                                x_we = 1; x_wdata = sbits;
                            end
                        end else begin
                            x_oe = 0;
                        end
                    end else if (k == 9) begin
                        k = 0;
                        if (ph == 1 && !m_rw) begin
                            ph = 2; x_oe = 0;
                        end else if (ph == 2) begin
                            x_oe = 0;
                        end else if (ph == 1 || m_ok) begin
                            ph = 3; dbyte = mem[x_ptr]; x_oe = !dbyte[7];
                        end else begin
                            ph = 0;
                        end
                    end else if (ph == 3 && k >= 1 && k <= 7) begin
                        x_oe = !dbyte[7-k];
                    end
                end
            end
            p_scl = m_scl;
            p_sda = sda_line;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 model sda_oe", int'(sda_oe), int'(x_oe));
            check("R7 model bus_busy", int'(bus_busy), int'(x_busy));
            check("R4 model reg_we", int'(reg_we), int'(x_we));
            check("R4 model reg_wdata", int'(reg_wdata), int'(x_wdata));
            check("R3 model reg_addr", int'(reg_addr), x_ptr);
        end
    end

    // ---------------- bus controller tasks -------------------------------------
    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
        wait_q();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wait_q();
        m_scl = 1'b1; wait_q(); wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        b = sda_line; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic nak);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(nak);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic nak);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(nak);
    endtask

    // ---------------- scenario --------------------------------------------------
    initial begin
        logic nak;
        logic [7:0] v;
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 sda_oe after reset", int'(sda_oe), 0);
        check("R10 bus_busy after reset", int'(bus_busy), 0);
        check("R10 reg_we after reset", int'(reg_we), 0);
        check("R10 reg_addr after reset", int'(reg_addr), 0);

        // matched write: pointer 2, then two data bytes
        do_start();
        send_byte(8'h9A, nak);
        check("R1 address acknowledged", int'(nak), 0);
        check("R7 busy after match", int'(bus_busy), 1);
        base = we_cnt;
        send_byte(8'h02, nak);
        check("R3 pointer byte acknowledged", int'(nak), 0);
        check("R3 pointer loaded", int'(reg_addr), 2);
        check("R3 pointer byte writes nothing", we_cnt - base, 0);
        send_byte(8'hA5, nak);
        check("R4 data byte acknowledged", int'(nak), 0);
        send_byte(8'h3C, nak);
        check("R4 one strobe per data byte", we_cnt - base, 2);
        check("R4 register holds last byte", int'(mem[2]), 'h3C);
        do_stop();
        check("R8 busy cleared by stop", int'(bus_busy), 0);
        check("R8 line released after stop", int'(sda_oe), 0);

        // read the pointed register twice, then no-acknowledge
        do_start();
        send_byte(8'h9B, nak);
        check("R1 read address acknowledged", int'(nak), 0);
        recv_byte(v, 1'b0);
        check("R5 first read byte", int'(v), 'h3C);
        recv_byte(v, 1'b1);
        check("R6 reload after acknowledge", int'(v), 'h3C);
        recv_byte(v, 1'b1);
        check("R6 released after no-acknowledge", int'(v), 'hFF);
        do_stop();

        // non-matching address is ignored
        base = we_cnt;
        do_start();
        send_byte(8'h9C, nak);
        check("R2 foreign address not acknowledged", int'(nak), 1);
        check("R2 busy stays low", int'(bus_busy), 0);
        send_byte(8'h01, nak);
        check("R2 following byte not acknowledged", int'(nak), 1);
        send_byte(8'h77, nak);
        do_stop();
        check("R2 no register written", we_cnt - base, 0);
        check("R2 pointer kept", int'(reg_addr), 2);

        // pointer-only write with high bits, repeated start into read
        do_start();
        send_byte(8'h9A, nak);
        send_byte(8'hFD, nak);
        check("R3 pointer keeps low bits", int'(reg_addr), 5);
        do_start();
        check("R7 busy held across repeated start", int'(bus_busy), 1);
        send_byte(8'h9B, nak);
        check("R9 read after repeated start acknowledged", int'(nak), 0);
        recv_byte(v, 1'b1);
        check("R9 reads pointed register", int'(v), int'(init_val(5)));
        do_stop();

        // new strap value
        strap = 3'b010;
        do_start();
        send_byte(8'h9A, nak);
        check("R2 old address refused after strap change", int'(nak), 1);
        do_stop();
        do_start();
        send_byte(8'h94, nak);
        check("R1 strapped address acknowledged", int'(nak), 0);
        send_byte(8'h01, nak);
        send_byte(8'hC3, nak);
        do_stop();
        check("R4 write at new address", int'(mem[1]), 'hC3);
        do_start();
        send_byte(8'h95, nak);
        recv_byte(v, 1'b1);
        check("R9 pointer retained between transfers", int'(v), 'hC3);
        do_stop();

        repeat (10) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

endmodule